// File: doc/BRIEF.md
# Prioritized CPU Interrupt Request Controller

This block decides, at every instruction boundary of a small 8-bit processor core, whether an interrupt is taken and which one. It watches five request lines. The first is a non-maskable trap. Three are maskable restart levels, called high, mid and low here. The last is a general request that needs an opcode from an external device. It also holds the global interrupt enable and three per-level mask bits, which software writes.

When the core marks the last clock of an instruction with `instr_end`, the block picks the winning request. One cycle later it pulses `irq_take` and presents the restart vector on `irq_vec`. For a general request it raises `irq_ext` instead, because the opcode comes from outside. In that case the block replaces the core's read strobe with an acknowledge strobe during the next opcode-fetch cycle. Accepting any interrupt clears the global enable. The high level is captured by a rising-edge latch. The mid and low levels follow their input levels.

The sequencer has three states, each named for what it does:
- `ST_RUN`: normal execution; arbitration happens here.
- `ST_ACK_WAIT`: a general request has been accepted and the block is waiting for the fetch cycle.
- `ST_ACK_FETCH`: the fetch cycle in which acknowledge is given.

The transitions are:
- `ST_RUN` to `ST_ACK_WAIT` when a general request wins.
- `ST_ACK_WAIT` to `ST_ACK_FETCH` when `fetch_cyc` is seen.
- `ST_ACK_FETCH` to `ST_RUN` when `fetch_cyc` drops.
- Every other case stays in the current state.

Top module: `intr_prio_ctrl`

## Requirements
- R1: The trap request is accepted at any instruction boundary. The global enable, the masks and all other requests have no effect on it. Its vector is 0x0024.
- R2: The priority order is trap, then high, then mid, then low, then general. Restart vectors are 0x003C for high, 0x0034 for mid and 0x002C for low. A general acceptance raises `irq_ext` with `irq_vec` = 0.
- R3: A restart level is accepted only when the global enable is 1 and its own mask bit is 0. The general request needs only the global enable.
- R4: Requests are sampled only in a cycle with `instr_end` high while the sequencer is in `ST_RUN`. `irq_take` pulses for exactly the following cycle, and it never pulses otherwise.
- R5: `ie_set` sets the global enable and `ie_clr` clears it. Reset clears it, and so does every acceptance, including a trap. Acceptance wins over `ie_set` in the same cycle.
- R6: The high level sets a latch on a rising edge of `rq_hi`. The latch stays set after the input drops. It is cleared when that level is accepted, or by a mask write with bit 4 set. Mid and low are level-sensitive.
- R7: A mask write (`mask_wr`) with bit 3 set loads the masks from bits 2:0: bit 0 is low, bit 1 is mid and bit 2 is high. Without bit 3 the masks are unchanged. Reset sets all three masks.
- R8: After a general acceptance, the next cycle with `fetch_cyc` high drives `ack_out` from `rd_in` and holds `rd_out` at 0. Once that fetch ends, `rd_out` follows `rd_in` again.
- R9: The `status` bit layout is:
  - bits 2:0: masks (low, mid, high)
  - bit 3: global enable
  - bits 6:4: pending (low level, mid level, high latch)
- R10: After reset, `irq_take`, `irq_ext` and `ack_out` are 0. The enable is 0, the masks are all set, and the high latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Non-maskable trap request |
| rq_hi | input | 1 | Highest restart level, edge-captured |
| rq_mid | input | 1 | Middle restart level |
| rq_lo | input | 1 | Lowest restart level |
| gen_req | input | 1 | General request that needs an external opcode |
| instr_end | input | 1 | Last clock of the current instruction |
| ie_set | input | 1 | Set the global enable |
| ie_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 5 | Mask write value |
| fetch_cyc | input | 1 | Core is in an opcode-fetch cycle |
| rd_in | input | 1 | Core read strobe |
| rd_out | output | 1 | Read strobe toward memory |
| ack_out | output | 1 | Acknowledge strobe toward the external device |
| irq_take | output | 1 | Interrupt accepted |
| irq_ext | output | 1 | Accepted request needs an external opcode |
| irq_vec | output | 16 | Restart vector of the accepted request |
| status | output | 7 | Masks, enable and pending bits |

## Verification
The assertions check on every cycle the rules that hold whatever the stimulus:
- a trap at a free boundary is always taken with its vector;
- no acceptance happens outside a boundary, or while the enable is off and no trap is present;
- every acceptance leaves the enable cleared;
- acknowledge appears only inside a fetch cycle, and the read strobe is suppressed while it does.

The full priority ordering across every mix of requests, enable and masks can only be shown by the bench's scenarios. The same holds for the edge-capture and clear behaviour of the high latch, the ignored mask write, and the return of the plain read strobe after the acknowledged fetch.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

    localparam int VEC_W      = 16;
    localparam int N_RST      = 3;   // maskable restart levels
    localparam int VEC_BASE   = 16'h0024;
    localparam int VEC_STRIDE = 8;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ACK_WAIT,
        ST_ACK_FETCH
    } seq_state_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_HI,
        SRC_MID,
        SRC_LO,
        SRC_GEN
    } src_t;

    // Restart vector for a source; trap at the base, then low, mid, high
    function automatic logic [VEC_W-1:0] vec_of(input src_t s);
        logic [VEC_W-1:0] v;
        unique case (s)
            SRC_TRAP: v = VEC_W'(VEC_BASE);
            SRC_LO:   v = VEC_W'(VEC_BASE + 1 * VEC_STRIDE);
            SRC_MID:  v = VEC_W'(VEC_BASE + 2 * VEC_STRIDE);
            SRC_HI:   v = VEC_W'(VEC_BASE + 3 * VEC_STRIDE);
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/intr_edge_latch.sv
module intr_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic service,
    input  logic sw_clear,
    output logic pending
);
    logic req_prev;
    logic rise;

    assign rise = req_in && !req_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= 1'b0;
            pending  <= 1'b0;
        end else begin
            req_prev <= req_in;
            if (rise)
                pending <= 1'b1;
            else if (service || sw_clear)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_mask_regs.sv
module intr_mask_regs
    import intr_prio_pkg::*;
#(
    parameter int NLEV = N_RST
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_set,
    input  logic            ie_clr,
    input  logic            accept,
    input  logic            mask_wr,
    input  logic            mask_en,
    input  logic [NLEV-1:0] mask_val,
    output logic            ie,
    output logic [NLEV-1:0] mask
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie <= 1'b0;
        else if (accept || ie_clr)
            ie <= 1'b0;
        else if (ie_set)
            ie <= 1'b1;
    end

    for (genvar k = 0; k < NLEV; k++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[k] <= 1'b1;
            else if (mask_wr && mask_en)
                mask[k] <= mask_val[k];
        end
    end
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
    import intr_prio_pkg::*;
(
    input  logic       trap_req,
    input  logic       hi_pend,
    input  logic       mid_lvl,
    input  logic       lo_lvl,
    input  logic       gen_req,
    input  logic       ie,
    input  logic [2:0] mask,
    output src_t       winner
);
    logic hi_ok, mid_ok, lo_ok, gen_ok;

    assign hi_ok  = hi_pend && ie && !mask[2];
    assign mid_ok = mid_lvl && ie && !mask[1];
    assign lo_ok  = lo_lvl  && ie && !mask[0];
    assign gen_ok = gen_req && ie;

    always_comb begin
        if (trap_req)     winner = SRC_TRAP;
        else if (hi_ok)   winner = SRC_HI;
        else if (mid_ok)  winner = SRC_MID;
        else if (lo_ok)   winner = SRC_LO;
        else if (gen_ok)  winner = SRC_GEN;
        else              winner = SRC_NONE;
    end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_end,
    input  src_t             winner,
    input  logic             fetch_cyc,
    input  logic             rd_in,
    output logic             accept,
    output logic             hi_serviced,
    output logic             busy,
    output logic             rd_out,
    output logic             ack_out,
    output logic             irq_take,
    output logic             irq_ext,
    output logic [VEC_W-1:0] irq_vec
);
    seq_state_t state, state_nx;

    assign accept      = (state == ST_RUN) && instr_end && (winner != SRC_NONE);
    assign hi_serviced = accept && (winner == SRC_HI);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:       if (accept && winner == SRC_GEN) state_nx = ST_ACK_WAIT;
            ST_ACK_WAIT:  if (fetch_cyc)                   state_nx = ST_ACK_FETCH;
            ST_ACK_FETCH: if (!fetch_cyc)                  state_nx = ST_RUN;
            default:                                       state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // registered acceptance outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take <= 1'b0;
            irq_ext  <= 1'b0;
            irq_vec  <= '0;
        end else begin
            irq_take <= accept;
            irq_ext  <= accept && (winner == SRC_GEN);
            irq_vec  <= accept ? vec_of(winner) : '0;
        end
    end

    // strobe steering
    always_comb begin
        busy    = 1'b1;
        rd_out  = 1'b0;
        ack_out = 1'b0;
        unique case (state)
            ST_RUN: begin
                busy   = 1'b0;
                rd_out = rd_in;
            end
            ST_ACK_WAIT, ST_ACK_FETCH: begin
                ack_out = fetch_cyc && rd_in;
                rd_out  = !fetch_cyc && rd_in;
            end
            default: rd_out = rd_in;
        endcase
    end
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl
    import intr_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic             rq_hi,
    input  logic             rq_mid,
    input  logic             rq_lo,
    input  logic             gen_req,
    input  logic             instr_end,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             mask_wr,
    input  logic [4:0]       mask_data,
    input  logic             fetch_cyc,
    input  logic             rd_in,
    output logic             rd_out,
    output logic             ack_out,
    output logic             irq_take,
    output logic             irq_ext,
    output logic [VEC_W-1:0] irq_vec,
    output logic [6:0]       status
);
    logic       hi_pend, ie, accept, hi_serviced, busy;
    logic [2:0] mask;
    src_t       winner;

    intr_edge_latch u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (rq_hi),
        .service  (hi_serviced),
        .sw_clear (mask_wr && mask_data[4]),
        .pending  (hi_pend)
    );

    intr_mask_regs #(.NLEV(N_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_set   (ie_set),
        .ie_clr   (ie_clr),
        .accept   (accept),
        .mask_wr  (mask_wr),
        .mask_en  (mask_data[3]),
        .mask_val (mask_data[2:0]),
        .ie       (ie),
        .mask     (mask)
    );

    intr_prio_pick u_pick (
        .trap_req (trap_req),
        .hi_pend  (hi_pend),
        .mid_lvl  (rq_mid),
        .lo_lvl   (rq_lo),
        .gen_req  (gen_req),
        .ie       (ie),
        .mask     (mask),
        .winner   (winner)
    );

    intr_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_end   (instr_end),
        .winner      (winner),
        .fetch_cyc   (fetch_cyc),
        .rd_in       (rd_in),
        .accept      (accept),
        .hi_serviced (hi_serviced),
        .busy        (busy),
        .rd_out      (rd_out),
        .ack_out     (ack_out),
        .irq_take    (irq_take),
        .irq_ext     (irq_ext),
        .irq_vec     (irq_vec)
    );

    assign status = {hi_pend, rq_mid, rq_lo, ie, mask};
endmodule

// File: rtl/intr_prio_chk.sv
module intr_prio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_req,
    input logic        instr_end,
    input logic        fetch_cyc,
    input logic        busy,
    input logic        rd_out,
    input logic        ack_out,
    input logic        irq_take,
    input logic        irq_ext,
    input logic [15:0] irq_vec,
    input logic [6:0]  status
);
    // R1: a trap at a free boundary is taken next cycle with its vector
    a_r1_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && trap_req && !busy) |=> (irq_take && irq_vec == 16'h0024));

    // R2: an external acceptance carries no internal vector
    a_r2_ext_novec: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_ext) |-> (irq_vec == 16'h0000));

    // R3: with the enable off, only a trap can be accepted
    a_r3_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_end && !trap_req && !status[3]) |=> !irq_take);

    // R4: acceptance only follows a boundary cycle
    a_r4_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(instr_end));

    // R5: the enable is off whenever an acceptance is reported
    a_r5_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !status[3]);

    // R8: acknowledge only inside a fetch cycle, with read suppressed
    a_r8_ack_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> (fetch_cyc && !rd_out));
endmodule

bind intr_prio_ctrl intr_prio_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req),
    .instr_end (instr_end),
    .fetch_cyc (fetch_cyc),
    .busy      (busy),
    .rd_out    (rd_out),
    .ack_out   (ack_out),
    .irq_take  (irq_take),
    .irq_ext   (irq_ext),
    .irq_vec   (irq_vec),
    .status    (status)
);

// File: tb/sim_intr_prio_ctrl.sv
module sim_intr_prio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic trap_req = 0, rq_hi = 0, rq_mid = 0, rq_lo = 0, gen_req = 0;
    logic instr_end = 0, ie_set = 0, ie_clr = 0, mask_wr = 0;
    logic [4:0] mask_data = '0;
    logic fetch_cyc = 0, rd_in = 0;
    logic rd_out, ack_out, irq_take, irq_ext;
    logic [15:0] irq_vec;
    logic [6:0] status;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_prio_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0; trap_req = 0; rq_hi = 0; rq_mid = 0; rq_lo = 0; gen_req = 0;
        instr_end = 0; ie_set = 0; ie_clr = 0; mask_wr = 0; mask_data = '0;
        fetch_cyc = 0; rd_in = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic wr_mask(input logic [4:0] d);
        mask_wr = 1; mask_data = d; tick(); mask_wr = 0; mask_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10 reset state
        do_reset();
        chk("R10 take", irq_take, 0);
        chk("R10 ext", irq_ext, 0);
        chk("R10 ack", ack_out, 0);
        chk("R10 status", status, 7'b000_0_111);

        // Exhaustive sweep: 5 requests x enable x 3 masks
        for (int c = 0; c < 512; c++) begin
            logic t, h, m, l, g, e;
            logic [2:0] mk;
            logic [15:0] ev;
            logic et, ex;
            t = c[0]; h = c[1]; m = c[2]; l = c[3]; g = c[4]; e = c[5]; mk = c[8:6];
            do_reset();
            wr_mask({2'b01, mk});
            if (e) begin ie_set = 1; tick(); ie_set = 0; end
            trap_req = t; rq_mid = m; rq_lo = l; gen_req = g; rq_hi = h;
            tick();
            // R9 status layout before boundary
            chk("R9 status", status, {h, m, l, e, mk});
            // expected winner
            et = 1; ex = 0; ev = 16'h0000;
            if (t)                    ev = 16'h0024;
            else if (h && e && !mk[2]) ev = 16'h003C;
            else if (m && e && !mk[1]) ev = 16'h0034;
            else if (l && e && !mk[0]) ev = 16'h002C;
            else if (g && e)           ex = 1;
            else                       et = 0;
            // R4: no take without boundary
            tick();
            chk("R4 no take", irq_take, 0);
            instr_end = 1; tick(); instr_end = 0;
            chk("R2 R3 take", irq_take, et);
            chk("R1 R2 vec", irq_vec, ev);
            chk("R2 ext", irq_ext, ex);
            chk("R5 ie after", status[3], e && !et);
            trap_req = 0; rq_hi = 0; rq_mid = 0; rq_lo = 0; gen_req = 0;
            tick();
            chk("R4 pulse", irq_take, 0);
            // R6 latch cleared only when high was serviced
            chk("R6 latch", status[6], h && !(ev == 16'h003C));
            if (ex) begin
                tick();
                chk("R8 rd before fetch", rd_out, 0);
                fetch_cyc = 1; rd_in = 1; #1;
                chk("R8 ack", ack_out, 1);
                chk("R8 rd held", rd_out, 0);
                tick(); tick();
                fetch_cyc = 0; rd_in = 0; tick();
                fetch_cyc = 1; rd_in = 1; #1;
                chk("R8 rd restored", rd_out, 1);
                chk("R8 ack gone", ack_out, 0);
                fetch_cyc = 0; rd_in = 0;
            end
        end

        // R5 acceptance beats ie_set, ie_clr works
        do_reset();
        ie_set = 1; tick(); ie_set = 0;
        chk("R5 ie set", status[3], 1);
        ie_clr = 1; tick(); ie_clr = 0;
        chk("R5 ie clr", status[3], 0);
        ie_set = 1; tick();
        trap_req = 1; instr_end = 1; tick();
        ie_set = 0; trap_req = 0; instr_end = 0;
        chk("R5 accept wins", status[3], 0);

        // R6 latch holds after input drops, software clear, no re-set while held
        do_reset();
        rq_hi = 1; tick(); rq_hi = 0; tick(); tick();
        chk("R6 hold", status[6], 1);
        wr_mask(5'b10000);
        chk("R6 sw clear", status[6], 0);
        rq_hi = 1; tick(); tick();
        chk("R6 level no reset", status[6], 1);
        wr_mask(5'b10000);
        tick();
        chk("R6 held level no edge", status[6], 0);
        rq_hi = 0;

        // R7 write without set-enable ignored
        do_reset();
        wr_mask(5'b00000);
        chk("R7 ignored", status[2:0], 3'b111);
        wr_mask(5'b01010);
        chk("R7 load", status[2:0], 3'b010);

        // R4 no take while holding requests without boundary
        ie_set = 1; tick(); ie_set = 0;
        rq_lo = 1; trap_req = 1;
        for (int i = 0; i < 5; i++) begin tick(); chk("R4 idle", irq_take, 0); end
        rq_lo = 0; trap_req = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule